// File: doc/BRIEF.md
# Variable-Page Translation Buffer with Pinned Block Slots

This block is a small, fully associative address translation buffer. Each slot covers an aligned virtual range whose size is a 4 KiB base page times a power of four. It holds a physical base address and a set of access attributes. A combinational lookup port returns hit or miss in the same cycle, together with the translated physical address and the stored attributes. On a miss it returns a miss code that tells instruction fetches apart from data accesses.

Maintenance commands arrive on one valid/opcode interface. Each command is acknowledged one cycle later with a status code. Two kinds of insert are available: a two-step insert that sends the address first and the protection word second, and a one-step insert that carries a size code. The other commands are a range purge, a purge of every ordinary slot, and a forced write or clear of a pinned slot.

The lowest slots are pinned block slots. Ordinary purges and the replacement logic never touch them. Ordinary inserts go to the lowest free ordinary slot. When no ordinary slot is free, a rotating victim pointer chooses the slot to replace.

Top module: `vtlb_top`

## Requirements
- R1: On a hit, `lk_pa` equals the slot's physical base plus (`lk_addr` minus the slot's virtual start). The low 12 bits therefore always pass through unchanged.
- R2: On a miss, `lk_hit` is 0 and `lk_miss` is 2'b01 when `lk_fetch` is 1, or 2'b10 otherwise. On a hit, `lk_miss` is 2'b00.
- R3: Opcode 3 (sized insert) takes a size code from `cmd_data[3:0]` and a physical page number from `cmd_data[24:5]`. The range size is 4096 shifted left by twice the code. The virtual start is `cmd_addr` aligned down to that size. The physical base is the page number shifted left by 12, aligned down to the same size. The protection word comes from `cmd_prot`.
- R4: Every insert first removes each valid ordinary slot that overlaps the new range.
- R5: An insert uses the lowest-numbered free ordinary slot. When none is free, it replaces the slot at the victim pointer. The pointer then advances and wraps from slot 15 back to slot 4, the first ordinary slot. Slots 0..3 are pinned.
- R6: Opcode 4 (range purge) takes a size code from `cmd_addr[3:0]` and a range aligned down from `cmd_addr`. Code 0 covers exactly one 4 KiB page. The purge removes overlapping ordinary slots and keeps overlapping pinned slots.
- R7: Opcode 5 (purge all) clears every ordinary slot, resets the victim pointer to slot 4 and cancels a pending two-step insert. Valid pinned slots stay in place.
- R8: Opcode 1 records a pending one-page range at `cmd_addr` and a physical page number from `cmd_data[24:5]`. A following opcode 2 whose `cmd_addr` lies inside that pending range completes the insert. Otherwise, or when nothing is pending, opcode 2 is dropped with status 2.
- R9: The protection word holds the access id in bits 18:1, U in bit 19, the second privilege level in bits 21:20, the first level in bits 23:22, the type in bits 26:24, B in bit 27, D in bit 28 and T in bit 29. `lk_attr` returns the stored fields in the same positions, with bits 31:30 and bit 0 at zero.
- R10: Opcode 6 writes pinned slot `cmd_slot` with the range `cmd_addr` (page-aligned) through start + `cmd_len` pages - 1 and the physical page from `cmd_data[24:5]`. It forces T to 0 and D to 1. A slot of 4 or more, or a length of 0, returns status 1 and changes nothing.
- R11: Opcode 7 clears pinned slot `cmd_slot`. A slot of 4 or more returns status 1.
- R12: Every command is acknowledged with `ack` high exactly one cycle after it is accepted. The status is 0 when no error applies. Opcode 0 does nothing. When several slots match a lookup, the lowest-numbered slot wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command opcode |
| cmd_addr | input | 32 | Virtual address; low 4 bits carry the size code for purges |
| cmd_data | input | 32 | Size code and physical page number operand |
| cmd_prot | input | 32 | Protection word |
| cmd_slot | input | 4 | Pinned slot index |
| cmd_len | input | 16 | Pinned range length in pages |
| lk_addr | input | 32 | Lookup virtual address |
| lk_fetch | input | 1 | Lookup is an instruction fetch |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 32 | Translated physical address |
| lk_attr | output | 32 | Stored attributes in protection-word layout |
| lk_miss | output | 2 | Miss code |
| ack | output | 1 | Command acknowledge |
| status | output | 2 | 0 ok, 1 invalid argument, 2 insert dropped |

## Verification
The bench targets the corner cases where a wrong design would drift silently. These are:
- a 16 KiB insert with a misaligned page number, which a design without alignment would translate to the wrong physical page;
- an insert that overlaps a larger ordinary entry, which would leave a stale translation behind if the overlap purge were missing;
- a range purge over a pinned block, which would lose the block if the pin mask were ignored.

The replacement pointer is driven through a full wrap. It is then checked again after purge-all, where a pointer that was not reset would evict the second ordinary slot instead of the first. It is also checked against a hole left by a purge, where skipping the free-slot search would evict a live entry. Finally, the bench checks the two-step insert against a mismatched second address and against a cancelling purge-all, which a faulty design would complete anyway.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;

    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_MAP_ADDR  = 3'd1,
        OP_MAP_PROT  = 3'd2,
        OP_MAP_SIZED = 3'd3,
        OP_PURGE     = 3'd4,
        OP_PURGE_ALL = 3'd5,
        OP_PIN_SET   = 3'd6,
        OP_PIN_CLR   = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_BAD_ARG = 2'd1,
        ST_DROPPED = 2'd2
    } status_e;

    // Field order mirrors protection word bits 29:1 (R9)
    typedef struct packed {
        logic        trap;
        logic        dirty;
        logic        brk;
        logic [2:0]  kind;
        logic [1:0]  lvl_hi;
        logic [1:0]  lvl_lo;
        logic        user;
        logic [17:0] aid;
    } attr_t;

    function automatic attr_t word_to_attr(logic [31:0] w);
        return attr_t'(w[29:1]);
    endfunction

    function automatic logic [31:0] attr_to_word(attr_t a);
        return {2'b00, a, 1'b0};
    endfunction

endpackage

// File: rtl/vtlb_cam.sv
module vtlb_cam #(
    parameter int ENTRIES = 16,
    parameter int VA_W    = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]           ent_vld,
    input  logic [ENTRIES-1:0][VA_W-1:0] ent_lo,
    input  logic [ENTRIES-1:0][VA_W-1:0] ent_hi,
    input  logic [VA_W-1:0]              probe_addr,
    input  logic [VA_W-1:0]              rng_lo,
    input  logic [VA_W-1:0]              rng_hi,
    output logic                         hit,
    output logic [IDX_W-1:0]             hit_idx,
    output logic [ENTRIES-1:0]           ovl_vec
);
    logic [ENTRIES-1:0] hit_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign hit_vec[g] = ent_vld[g] && (probe_addr >= ent_lo[g]) && (probe_addr <= ent_hi[g]);
        assign ovl_vec[g] = ent_vld[g] && (ent_lo[g] <= rng_hi) && (ent_hi[g] >= rng_lo);
    end

    // lowest index wins
    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/vtlb_alloc.sv
module vtlb_alloc #(
    parameter int ENTRIES = 16,
    parameter int PINNED  = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] occ,
    input  logic [IDX_W-1:0]   rr,
    output logic [IDX_W-1:0]   slot,
    output logic               from_victim
);
    always_comb begin
        slot        = rr;
        from_victim = 1'b1;
        for (int i = ENTRIES - 1; i >= PINNED; i--) begin
            if (!occ[i]) begin
                slot        = IDX_W'(i);
                from_victim = 1'b0;
            end
        end
    end

endmodule

// File: rtl/vtlb_top.sv
module vtlb_top
    import vtlb_pkg::*;
#(
    parameter int ENTRIES   = 16,
    parameter int PINNED    = 4,
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int PPN_LSB   = 5,
    parameter int LEN_W     = 16,
    localparam int IDX_W    = $clog2(ENTRIES),
    localparam int PPN_W    = PA_W - PAGE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [VA_W-1:0]  cmd_addr,
    input  logic [31:0]      cmd_data,
    input  logic [31:0]      cmd_prot,
    input  logic [IDX_W-1:0] cmd_slot,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [VA_W-1:0]  lk_addr,
    input  logic             lk_fetch,
    output logic             lk_hit,
    output logic [PA_W-1:0]  lk_pa,
    output logic [31:0]      lk_attr,
    output logic [1:0]       lk_miss,
    output logic             ack,
    output logic [1:0]       status
);
    localparam logic [ENTRIES-1:0] PIN_MASK = {{(ENTRIES-PINNED){1'b0}}, {PINNED{1'b1}}};
    localparam logic [VA_W-1:0]    PAGE_M   = VA_W'((64'd1 << PAGE_BITS) - 64'd1);

    typedef struct packed {
        logic [ENTRIES-1:0]           vld;
        logic [ENTRIES-1:0][VA_W-1:0] lo;
        logic [ENTRIES-1:0][VA_W-1:0] hi;
        logic [ENTRIES-1:0][PA_W-1:0] pa;
        attr_t [ENTRIES-1:0]          at;
        logic [IDX_W-1:0]             rr;
        logic                         pend;
        logic [VA_W-1:0]              pend_lo;
        logic [PA_W-1:0]              pend_pa;
        logic                         ack;
        logic [1:0]                   status;
    } state_t;

    function automatic logic [VA_W-1:0] va_span(logic [3:0] code);
        logic [63:0] m;
        int lg;
        lg = PAGE_BITS + 2 * int'(code);
        m  = (lg >= 64) ? '1 : ((64'd1 << lg) - 64'd1);
        return (lg >= VA_W) ? '1 : m[VA_W-1:0];
    endfunction

    function automatic logic [PA_W-1:0] pa_span(logic [3:0] code);
        logic [63:0] m;
        int lg;
        lg = PAGE_BITS + 2 * int'(code);
        m  = (lg >= 64) ? '1 : ((64'd1 << lg) - 64'd1);
        return (lg >= PA_W) ? '1 : m[PA_W-1:0];
    endfunction

    state_t st_d, st_q;
    op_e    op;

    logic [VA_W-1:0]    rng_lo, rng_hi, ins_m, prg_m;
    logic [PA_W-1:0]    ppn_pa;
    logic               in_pend, purge_en;
    logic [ENTRIES-1:0] ovl_vec, kept_vld;
    logic               hit, from_victim;
    logic [IDX_W-1:0]   hit_idx, new_slot, rr_q;
    logic               unused_bits;

    assign op          = op_e'(cmd_op);
    assign ins_m       = va_span(cmd_data[3:0]);
    assign prg_m       = va_span(cmd_addr[3:0]);
    assign ppn_pa      = {cmd_data[PPN_LSB +: PPN_W], {PAGE_BITS{1'b0}}};
    assign unused_bits = ^{cmd_data, cmd_prot};
    assign rr_q        = st_q.rr;

    always_comb begin
        rng_lo = cmd_addr & ~PAGE_M;
        rng_hi = rng_lo | PAGE_M;
        case (op)
            OP_MAP_PROT: begin
                rng_lo = st_q.pend_lo;
                rng_hi = st_q.pend_lo | PAGE_M;
            end
            OP_MAP_SIZED: begin
                rng_lo = cmd_addr & ~ins_m;
                rng_hi = (cmd_addr & ~ins_m) | ins_m;
            end
            OP_PURGE: begin
                rng_lo = cmd_addr & ~prg_m;
                rng_hi = (cmd_addr & ~prg_m) | prg_m;
            end
            default: ;
        endcase
    end

    assign in_pend  = st_q.pend && (cmd_addr >= st_q.pend_lo) && (cmd_addr <= (st_q.pend_lo | PAGE_M));
    assign purge_en = cmd_valid && ((op == OP_MAP_ADDR) || (op == OP_MAP_SIZED) ||
                                    (op == OP_PURGE) || ((op == OP_MAP_PROT) && in_pend));
    assign kept_vld = purge_en ? (st_q.vld & ~(ovl_vec & ~PIN_MASK)) : st_q.vld;

    vtlb_cam #(.ENTRIES(ENTRIES), .VA_W(VA_W)) cam_i (
        .ent_vld    (st_q.vld),
        .ent_lo     (st_q.lo),
        .ent_hi     (st_q.hi),
        .probe_addr (lk_addr),
        .rng_lo     (rng_lo),
        .rng_hi     (rng_hi),
        .hit        (hit),
        .hit_idx    (hit_idx),
        .ovl_vec    (ovl_vec)
    );

    vtlb_alloc #(.ENTRIES(ENTRIES), .PINNED(PINNED)) alloc_i (
        .occ         (kept_vld),
        .rr          (st_q.rr),
        .slot        (new_slot),
        .from_victim (from_victim)
    );

    always_comb begin
        st_d        = st_q;
        st_d.vld    = kept_vld;
        st_d.ack    = cmd_valid;
        st_d.status = ST_OK;
        if (cmd_valid) begin
            case (op)
                OP_MAP_ADDR: begin
                    st_d.pend    = 1'b1;
                    st_d.pend_lo = rng_lo;
                    st_d.pend_pa = ppn_pa;
                end
                OP_MAP_PROT, OP_MAP_SIZED: begin
                    st_d.pend = (op == OP_MAP_PROT) ? 1'b0 : st_q.pend;
                    if ((op == OP_MAP_PROT) && !in_pend) begin
                        st_d.status = ST_DROPPED;
                    end else begin
                        st_d.vld[new_slot] = 1'b1;
                        st_d.lo[new_slot]  = rng_lo;
                        st_d.hi[new_slot]  = rng_hi;
                        st_d.pa[new_slot]  = (op == OP_MAP_PROT) ? st_q.pend_pa
                                                                 : (ppn_pa & ~pa_span(cmd_data[3:0]));
                        st_d.at[new_slot]  = word_to_attr(cmd_prot);
                        if (from_victim) begin
                            st_d.rr = (new_slot == IDX_W'(ENTRIES - 1)) ? IDX_W'(PINNED)
                                                                        : new_slot + 1'b1;
                        end
                    end
                end
                OP_PURGE_ALL: begin
                    st_d.vld  = st_q.vld & PIN_MASK;
                    st_d.rr   = IDX_W'(PINNED);
                    st_d.pend = 1'b0;
                end
                OP_PIN_SET: begin
                    if ((cmd_slot < IDX_W'(PINNED)) && (cmd_len != '0)) begin
                        st_d.vld[cmd_slot]      = 1'b1;
                        st_d.lo[cmd_slot]       = cmd_addr & ~PAGE_M;
                        st_d.hi[cmd_slot]       = (cmd_addr & ~PAGE_M) + (VA_W'(cmd_len) << PAGE_BITS) - VA_W'(1);
                        st_d.pa[cmd_slot]       = ppn_pa;
                        st_d.at[cmd_slot]       = word_to_attr(cmd_prot);
                        st_d.at[cmd_slot].trap  = 1'b0;
                        st_d.at[cmd_slot].dirty = 1'b1;
                    end else begin
                        st_d.status = ST_BAD_ARG;
                    end
                end
                OP_PIN_CLR: begin
                    if (cmd_slot < IDX_W'(PINNED)) st_d.vld[cmd_slot] = 1'b0;
                    else                            st_d.status        = ST_BAD_ARG;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.rr <= IDX_W'(PINNED);
        end else begin
            st_q <= st_d;
        end
    end

    assign lk_hit  = hit;
    assign lk_pa   = hit ? (st_q.pa[hit_idx] + PA_W'(lk_addr - st_q.lo[hit_idx])) : '0;
    assign lk_attr = hit ? attr_to_word(st_q.at[hit_idx]) : '0;
    assign lk_miss = hit ? 2'b00 : (lk_fetch ? 2'b01 : 2'b10);
    assign ack     = st_q.ack;
    assign status  = st_q.status;

endmodule

// File: rtl/vtlb_chk.sv
module vtlb_chk #(
    parameter int ENTRIES   = 16,
    parameter int PINNED    = 4,
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic [VA_W-1:0]  lk_addr,
    input logic             lk_fetch,
    input logic             lk_hit,
    input logic [PA_W-1:0]  lk_pa,
    input logic [1:0]       lk_miss,
    input logic             ack,
    input logic [1:0]       status,
    input logic [IDX_W-1:0] rr_q
);
    // R12
    ack_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> ack);

    // R12
    no_spurious_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !ack);

    // R8
    drop_only_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && status == 2'd2) |-> ($past(cmd_op) == 3'd2));

    // R10
    bad_arg_only_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && status == 2'd1) |-> ($past(cmd_op) == 3'd6 || $past(cmd_op) == 3'd7));

    // R1
    page_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_pa[PAGE_BITS-1:0] == lk_addr[PAGE_BITS-1:0]));

    // R2
    miss_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_miss == (lk_fetch ? 2'b01 : 2'b10)));

    // R5
    victim_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rr_q >= IDX_W'(PINNED)) && (rr_q <= IDX_W'(ENTRIES - 1)));

    // R7
    purge_all_rr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_valid && cmd_op == 3'd5) |-> (rr_q == IDX_W'(PINNED)));

endmodule

bind vtlb_top vtlb_chk #(
    .ENTRIES(ENTRIES), .PINNED(PINNED), .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .lk_addr(lk_addr), .lk_fetch(lk_fetch), .lk_hit(lk_hit), .lk_pa(lk_pa),
    .lk_miss(lk_miss), .ack(ack), .status(status), .rr_q(rr_q)
);

// File: tb/vtlb_top_tb_top.sv
module vtlb_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [31:0] cmd_addr = '0, cmd_data = '0, cmd_prot = '0;
    logic [3:0]  cmd_slot = '0;
    logic [15:0] cmd_len = '0;
    logic [31:0] lk_addr = '0;
    logic        lk_fetch = 1'b0;
    logic        lk_hit, ack;
    logic [31:0] lk_pa, lk_attr;
    logic [1:0]  lk_miss, status;

    int    n_chk = 0, n_fail = 0;
    bit    done = 0;
    int    exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    vtlb_top dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_prot(cmd_prot),
        .cmd_slot(cmd_slot), .cmd_len(cmd_len), .lk_addr(lk_addr), .lk_fetch(lk_fetch),
        .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_attr(lk_attr), .lk_miss(lk_miss),
        .ack(ack), .status(status)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mkprot(int aid, int u, int pl2, int pl1, int typ, int b, int d, int t);
        return (32'(aid) << 1) | (32'(u) << 19) | (32'(pl2) << 20) | (32'(pl1) << 22) |
               (32'(typ) << 24) | (32'(b) << 27) | (32'(d) << 28) | (32'(t) << 29);
    endfunction

    // monitor: pops expected status on every acknowledge
    always @(negedge clk) begin
        if (rst_n && ack) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R12 unexpected ack", 32'(ack), 32'd0);
            end else begin
                automatic int    e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(status == 2'(e), t, 32'(status), 32'(e));
            end
        end
    end

    task automatic cmd(input int op, input logic [31:0] a, input logic [31:0] d,
                       input logic [31:0] p, input int slot, input int len,
                       input int exp_st, input string tag);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_addr = a; cmd_data = d;
        cmd_prot = p; cmd_slot = 4'(slot); cmd_len = 16'(len);
        exp_q.push_back(exp_st);
        tag_q.push_back(tag);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic look(input logic [31:0] va, input logic f, input logic eh,
                        input logic [31:0] epa, input logic [31:0] eat, input string tag);
        @(negedge clk);
        lk_addr = va; lk_fetch = f;
        #1;
        chk(lk_hit == eh, {tag, " hit"}, 32'(lk_hit), 32'(eh));
        if (eh) begin
            chk(lk_pa == epa, {tag, " pa"}, lk_pa, epa);
            chk(lk_attr == eat, {tag, " attr"}, lk_attr, eat);
            chk(lk_miss == 2'b00, {tag, " R2 miss-on-hit"}, 32'(lk_miss), 32'd0);
        end else begin
            chk(lk_miss == (f ? 2'b01 : 2'b10), {tag, " R2 miss code"}, 32'(lk_miss), f ? 32'd1 : 32'd2);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] pw, px;
        pw = mkprot(18'h155, 1, 2, 1, 3, 0, 1, 0);
        px = mkprot(5, 0, 1, 2, 1, 0, 1, 0);
        repeat (4) @(negedge clk);
        chk(ack == 1'b0, "R12 ack low in reset", 32'(ack), 32'd0);
        rst_n = 1'b1;
        look(32'h1000, 1'b0, 1'b0, 0, 0, "R2 data miss after reset");
        look(32'h1000, 1'b1, 1'b0, 0, 0, "R2 fetch miss after reset");
        cmd(0, 0, 0, 0, 0, 0, 0, "R12 nop status");

        // two-step insert (R8, R9, R1)
        cmd(1, 32'h5000, 32'hABC << 5, 0, 0, 0, 0, "R8 step one");
        cmd(2, 32'h5123, 0, pw, 0, 0, 0, "R8 step two");
        look(32'h5ABC, 1'b0, 1'b1, 32'h00AB_CABC, pw, "R1 R9 two-step lookup");
        cmd(1, 32'h7000, 32'h11 << 5, 0, 0, 0, 0, "R8 step one b");
        cmd(2, 32'h9000, 0, pw, 0, 0, 2, "R8 mismatched step two dropped");
        look(32'h7000, 1'b0, 1'b0, 0, 0, "R8 dropped insert absent");
        cmd(2, 32'h7000, 0, pw, 0, 0, 2, "R8 step two without pending");

        // sized insert with misaligned page number (R3)
        cmd(3, 32'h0002_7FFF, 32'h1 | (32'h43 << 5), px, 0, 0, 0, "R3 sized insert");
        look(32'h0002_6123, 1'b0, 1'b1, 32'h0004_2123, px, "R3 16K translation");
        // overlapping smaller insert removes the large one (R4)
        cmd(3, 32'h0002_5000, 32'h99 << 5, px, 0, 0, 0, "R4 overlapping insert");
        look(32'h0002_6123, 1'b0, 1'b0, 0, 0, "R4 overlapped entry removed");
        look(32'h0002_5010, 1'b0, 1'b1, 32'h0009_9010, px, "R4 new entry");

        // pinned insert (R10)
        cmd(6, 32'h0010_0000, 32'h200 << 5, mkprot(7, 0, 0, 3, 2, 1, 0, 1), 2, 3, 0, "R10 pin insert");
        look(32'h0010_2FFF, 1'b0, 1'b1, 32'h0020_2FFF, mkprot(7, 0, 0, 3, 2, 1, 1, 0), "R10 pinned T0 D1");
        look(32'h0010_3000, 1'b0, 1'b0, 0, 0, "R10 pinned range end");
        cmd(6, 32'h0040_0000, 0, 0, 4, 1, 1, "R10 slot out of range");
        cmd(6, 32'h0040_0000, 0, 0, 1, 0, 1, "R10 zero length");
        look(32'h0040_0000, 1'b0, 1'b0, 0, 0, "R10 bad insert changed nothing");

        // range purges (R6)
        cmd(4, 32'h0010_0002, 0, 0, 0, 0, 0, "R6 purge 64K over pinned");
        look(32'h0010_1000, 1'b0, 1'b1, 32'h0020_1000, mkprot(7, 0, 0, 3, 2, 1, 1, 0), "R6 pinned kept");
        cmd(4, 32'h0000_5000, 0, 0, 0, 0, 0, "R6 single page purge");
        look(32'h0000_5ABC, 1'b0, 1'b0, 0, 0, "R6 page purged");
        look(32'h0002_5010, 1'b0, 1'b1, 32'h0009_9010, px, "R6 neighbour kept");

        // priority between overlapping pinned and ordinary (R12)
        cmd(3, 32'h0010_1000, 32'h333 << 5, px, 0, 0, 0, "R12 ordinary over pinned");
        look(32'h0010_1000, 1'b0, 1'b1, 32'h0020_1000, mkprot(7, 0, 0, 3, 2, 1, 1, 0), "R12 lowest slot wins");

        // purge all (R7)
        cmd(1, 32'h8000, 32'h5 << 5, 0, 0, 0, 0, "R7 pending before purge-all");
        cmd(5, 0, 0, 0, 0, 0, 0, "R7 purge all");
        cmd(2, 32'h8000, 0, px, 0, 0, 2, "R7 pending cancelled");
        look(32'h0002_5010, 1'b0, 1'b0, 0, 0, "R7 ordinary cleared");
        look(32'h0010_1000, 1'b1, 1'b1, 32'h0020_1000, mkprot(7, 0, 0, 3, 2, 1, 1, 0), "R7 pinned kept");

        // round robin with wrap (R5)
        for (int i = 0; i < 12; i++)
            cmd(3, 32'h1000_0000 + 32'(i) * 32'h1000, (32'h100 + 32'(i)) << 5, px, 0, 0, 0, "R5 fill A");
        for (int i = 0; i < 12; i++)
            cmd(3, 32'h1100_0000 + 32'(i) * 32'h1000, (32'h200 + 32'(i)) << 5, px, 0, 0, 0, "R5 fill B");
        cmd(3, 32'h1200_0000, 32'h300 << 5, px, 0, 0, 0, "R5 wrap insert C");
        look(32'h1000_B000, 1'b0, 1'b0, 0, 0, "R5 A evicted");
        look(32'h1100_0000, 1'b0, 1'b0, 0, 0, "R5 wrap evicted B0");
        look(32'h1100_1000, 1'b0, 1'b1, 32'h0020_1000, px, "R5 B1 kept");
        look(32'h1200_0004, 1'b0, 1'b1, 32'h0030_0004, px, "R5 C0 present");

        // pointer reset after purge all (R7, R5)
        cmd(5, 0, 0, 0, 0, 0, 0, "R7 purge all again");
        for (int i = 0; i < 12; i++)
            cmd(3, 32'h3000_0000 + 32'(i) * 32'h1000, (32'h400 + 32'(i)) << 5, px, 0, 0, 0, "R5 fill D");
        cmd(3, 32'h3100_0000, 32'h500 << 5, px, 0, 0, 0, "R7 insert E");
        look(32'h3000_0000, 1'b0, 1'b0, 0, 0, "R7 victim pointer reset");
        look(32'h3000_1008, 1'b0, 1'b1, 32'h0040_1008, px, "R7 D1 kept");

        // free slot before victim (R5)
        cmd(4, 32'h3000_5000, 0, 0, 0, 0, 0, "R5 open hole");
        cmd(3, 32'h3200_0000, 32'h600 << 5, px, 0, 0, 0, "R5 insert F");
        look(32'h3000_1008, 1'b0, 1'b1, 32'h0040_1008, px, "R5 free slot used first");
        look(32'h3200_0FFF, 1'b0, 1'b1, 32'h0060_0FFF, px, "R5 F present");

        // pinned purge (R11)
        cmd(7, 0, 0, 0, 9, 0, 1, "R11 slot out of range");
        look(32'h0010_1000, 1'b0, 1'b1, 32'h0020_1000, mkprot(7, 0, 0, 3, 2, 1, 1, 0), "R11 bad purge kept pin");
        cmd(7, 0, 0, 0, 2, 0, 0, "R11 pin purge");
        look(32'h0010_1000, 1'b1, 1'b0, 0, 0, "R11 pinned cleared");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R12 all commands acknowledged", 32'(exp_q.size()), 32'd0);
        finish_run();
    end

endmodule